// File: doc/BRIEF.md
# Byte-Level I2C Master Controller

This block is an I2C bus master driven by software through a small 32-bit register port. Each transfer moves one byte. Software requests a START by setting a level control bit. While that bit stays set the bus is held, and clearing it produces a STOP. A separate command bit gives a repeated START. Software writes the data register to send a byte. It reads the data register to collect the previous received byte and to launch the next one, so the first read after the address phase is a dummy that only starts reception.

Bus timing comes from a bit-rate register. The controller ticks once every N input clocks, and each SCL bit lasts 8 ticks: 4 with SCL low and 4 with SCL released. Between bytes SCL is held low until software acts. SCL and SDA are open-drain: an output-enable of 1 pulls the line low. Status flags report byte completion, the acknowledge received, arbitration loss and bus busy, and an interrupt line reports completion and arbitration loss.

Top module: `i2c_byte_master`

## Requirements
- R1: Registers: control at 0x04, status at 0x08, data at 0x0C, bit-rate at 0x14, soft reset at 0xFC. After reset, and after writing 1 then 0 to bit0 of 0x FC, control and status read 0, the bit-rate register reads 63 and neither line is driven.
- R2: With control bit7 (enable) at 1, setting control bit5 gives START (SDA falls while SCL is high) and clearing it gives STOP. Status bit5 (busy) is 1 from a detected START until a detected STOP.
- R3: One SCL bit lasts 8 times the bit-rate value in clocks. SCL stays low after each byte until software writes or reads the data register.
- R4: In transmit mode (control bit4 = 1), a data write made while the bus is held sends 8 bits MSB first. The ninth-clock acknowledge is stored in status bit0 (1 = NACK), and status bit7 (complete) and bit1 (interrupt flag) are set. A data write while the bus is not held is ignored.
- R5: In receive mode (control bit4 = 0), a data read returns the last received byte and starts the next one. On the ninth clock the controller drives control bit3 (1 = NACK, 0 = ACK). A data read in transmit mode starts nothing.
- R6: Writing control bit2 while the bus is held makes a repeated START: SDA is released with SCL low, SCL is released, then SDA is pulled low. Bit2 is not stored.
- R7: If SDA reads low while the controller is releasing it during a transmitted data bit, status bit4 (arbitration lost) is set, both lines are released, control bit5 is cleared and the transfer ends.
- R8: Writing 0 to a status bit clears it. If a completion falls in the same cycle as a clearing write, the flag is set.
- R9: The interrupt output equals (control bit9 OR bit8) AND (status bit1 OR status bit4), and it stays high until software clears those flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| scl_i | input | 1 | SCL line level |
| scl_o | output | 1 | SCL drive value, always 0 |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_i | input | 1 | SDA line level |
| sda_o | output | 1 | SDA drive value, always 0 |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Interrupt request |

## Verification
The collision of interest is a status-clearing write that lands in the same cycle in which a received byte completes. The bench starts a receive byte and then writes 0 to the status register on every cycle. It stops only once the interrupt is seen high, so the clearing write is always present on the edge where completion occurs. If the clear won that cycle, the flag would be wiped on every cycle and the interrupt would never appear. The outcome is judged by the interrupt going high and by the complete bit reading back as set.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int BRC_W    = 16,
  parameter int BRC_INIT = 63
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        scl_i,
  output logic        scl_o,
  output logic        scl_oe,
  input  logic        sda_i,
  output logic        sda_o,
  output logic        sda_oe,
  output logic        irq
);
  localparam logic [7:0] A_CTL = 8'h04, A_STS = 8'h08, A_DAT = 8'h0C, A_BRC = 8'h14, A_RST = 8'hFC;
  localparam logic [9:0] CTL_MASK = 10'h3B9;
  localparam logic [BRC_W-1:0] BRC_RST = BRC_W'(BRC_INIT);

  typedef enum logic [2:0] {S_IDLE, S_START, S_HOLD, S_BIT, S_RSTART, S_STOP} st_t;
  st_t st;

  logic [9:0]       ctl;
  logic [BRC_W-1:0] brc, divc;
  logic [7:0]       sh, rxb;
  logic [3:0]       bitn;
  logic [2:0]       ph;
  logic srst, sda_q, cmpl, arbl, iflg, nack_rx, busy, rxm, scl_p, sda_p;

  wire wr_ctl = reg_wr && reg_addr == A_CTL;
  wire wr_sts = reg_wr && reg_addr == A_STS;
  wire tick   = divc == '0;
  wire [BRC_W-1:0] reload = (brc > BRC_W'(1)) ? brc - BRC_W'(1) : '0;
  wire held   = st == S_HOLD;
  wire go_rs  = held && wr_ctl && reg_wdata[2];
  wire go_tx  = held && reg_wr && reg_addr == A_DAT && ctl[4];
  wire go_rx  = held && reg_rd && reg_addr == A_DAT && !ctl[4];
  wire samp   = st == S_BIT && tick && ph == 3'd6;
  wire bend   = tick && ph == 3'd7;
  wire done   = st == S_BIT && bend && bitn == 4'd8;
  wire lost   = samp && bitn < 4'd8 && !rxm && !sda_q && !sda_i;
  wire bitval = (bitn == 4'd8) ? (rxm && !ctl[3]) : (!rxm && !sh[7]);

  logic unused_hi;
  assign unused_hi = ^reg_wdata[31:10];

  assign scl_o  = 1'b0;
  assign sda_o  = 1'b0;
  assign sda_oe = sda_q;
  assign scl_oe = held || ((st == S_BIT || st == S_RSTART || st == S_STOP) && !ph[2]);
  assign irq    = |ctl[9:8] && (iflg || arbl);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) srst <= 1'b0;
    else if (reg_wr && reg_addr == A_RST) srst <= reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 1'b1; sda_p <= 1'b1; busy <= 1'b0;
    end else begin
      scl_p <= scl_i; sda_p <= sda_i;
      if (srst) busy <= 1'b0;
      else if (scl_p && scl_i && sda_p && !sda_i) busy <= 1'b1;
      else if (scl_p && scl_i && !sda_p && sda_i) busy <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; ctl <= '0; brc <= BRC_RST; divc <= '0; ph <= '0; bitn <= '0;
      sh <= '0; rxb <= '0; rxm <= 1'b0; sda_q <= 1'b0;
      cmpl <= 1'b0; arbl <= 1'b0; iflg <= 1'b0; nack_rx <= 1'b0;
    end else if (srst) begin
      st <= S_IDLE; ctl <= '0; brc <= BRC_RST; divc <= '0; ph <= '0; bitn <= '0;
      sh <= '0; rxb <= '0; rxm <= 1'b0; sda_q <= 1'b0;
      cmpl <= 1'b0; arbl <= 1'b0; iflg <= 1'b0; nack_rx <= 1'b0;
    end else begin
      if (wr_ctl) ctl <= reg_wdata[9:0] & CTL_MASK;
      if (reg_wr && reg_addr == A_BRC) brc <= reg_wdata[BRC_W-1:0];
      if (wr_sts) begin
        cmpl <= cmpl & reg_wdata[7]; arbl <= arbl & reg_wdata[4];
        iflg <= iflg & reg_wdata[1]; nack_rx <= nack_rx & reg_wdata[0];
      end
      if (st != S_IDLE && !held) begin
        divc <= tick ? reload : divc - BRC_W'(1);
        if (tick) ph <= ph + 3'd1;
      end
      case (st)
        S_IDLE:
          if (ctl[7] && ctl[5]) begin
            st <= S_START; sda_q <= 1'b1; ph <= '0; divc <= reload;
          end
        S_START:
          if (tick && ph == 3'd3) st <= S_HOLD;
        S_HOLD: begin
          if (go_rs) st <= S_RSTART;
          else if (go_tx) begin st <= S_BIT; sh <= reg_wdata[7:0]; rxm <= 1'b0; bitn <= '0; end
          else if (go_rx) begin st <= S_BIT; rxm <= 1'b1; bitn <= '0; end
          else if (!ctl[5]) st <= S_STOP;
          ph <= '0; divc <= reload;
        end
        S_BIT: begin
          if (tick && ph == 3'd0) sda_q <= bitval;
          if (samp) begin
            if (bitn < 4'd8) sh <= {sh[6:0], sda_i};
            else if (!rxm) nack_rx <= sda_i;
          end
          if (lost) begin
            arbl <= 1'b1; ctl[5] <= 1'b0; sda_q <= 1'b0; st <= S_IDLE;
          end else if (bend) begin
            if (bitn == 4'd8) begin
              st <= S_HOLD; cmpl <= 1'b1; iflg <= 1'b1;
              if (rxm) rxb <= sh;
            end else bitn <= bitn + 4'd1;
          end
        end
        S_RSTART: begin
          if (tick && ph == 3'd0) sda_q <= 1'b0;
          if (bend) begin st <= S_START; sda_q <= 1'b1; end
        end
        S_STOP: begin
          if (tick && ph == 3'd0) sda_q <= 1'b1;
          if (bend) begin st <= S_IDLE; sda_q <= 1'b0; end
        end
        default: st <= S_IDLE;
      endcase
    end

  always_comb
    case (reg_addr)
      A_CTL:   reg_rdata = {22'b0, ctl};
      A_STS:   reg_rdata = {24'b0, cmpl, 1'b0, busy, arbl, 2'b0, iflg, nack_rx};
      A_DAT:   reg_rdata = {24'b0, rxb};
      A_BRC:   reg_rdata = {{(32-BRC_W){1'b0}}, brc};
      A_RST:   reg_rdata = {31'b0, srst};
      default: reg_rdata = '0;
    endcase

  // R2: SDA moves with SCL released only for START, STOP or a lost arbitration
  p_sda_edges_r2: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (!scl_oe && !$past(scl_oe) && $changed(sda_oe)) |-> (st == S_START || st == S_IDLE));
  // R2: a byte only shifts while the bus monitor reports busy
  p_busy_in_byte_r2: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (st == S_BIT) |-> busy);
  // R8: completion wins over a simultaneous clearing write
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n || srst)
    $past(done) |-> (cmpl && iflg));
  // R7: losing arbitration leaves both lines released
  p_arb_release_r7: assert property (@(posedge clk) disable iff (!rst_n || srst)
    $rose(arbl) |-> (!scl_oe && !sda_oe));
  // R5: received byte register only updates after a receive byte
  p_rx_only_r5: assert property (@(posedge clk) disable iff (!rst_n || srst)
    $changed(rxb) |-> $past(rxm));
endmodule

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic scl_o, scl_oe, sda_o, sda_oe, irq;
  logic slv_sda = 1'b0, ext_sda = 1'b0, ack_en = 1'b1;
  wire scl_line = ~scl_oe;
  wire sda_line = ~(sda_oe | slv_sda | ext_sda);

  i2c_byte_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_i(scl_line), .scl_o(scl_o), .scl_oe(scl_oe),
    .sda_i(sda_line), .sda_o(sda_o), .sda_oe(sda_oe), .irq(irq));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc++;

  // slave model: ack, data return, byte log, master-ack capture, SCL period
  int sb = 0, starts = 0, nlog = 0, t_last = 0, t_prev = 0;
  logic pscl = 1'b1, psda = 1'b1, aph = 1'b0, rdm = 1'b0, nacked = 1'b0, mack = 1'b0;
  logic [7:0] ssh = '0, txb = 8'h5A;
  logic [7:0] logb [0:7];
  always @(scl_line or sda_line) begin
    if (scl_line === 1'b1 && pscl && psda && sda_line === 1'b0) begin
      starts++; sb = 0; aph = 1'b1; rdm = 1'b0; nacked = 1'b0; slv_sda = 1'b0;
    end else if (scl_line === 1'b1 && !pscl) begin
      t_prev = t_last; t_last = cyc;
      if (sb < 8) ssh = {ssh[6:0], sda_line};
      if (sb == 7) begin
        if (aph) rdm = ssh[0];
        else if (!rdm && nlog < 8) begin logb[nlog] = ssh; nlog++; end
      end
      if (sb == 8) begin
        if (rdm && !aph) begin mack = sda_line; nacked = sda_line; txb = txb + 8'd1; end
        aph = 1'b0;
      end
      sb = (sb == 8) ? 0 : sb + 1;
    end else if (scl_line === 1'b0 && pscl) begin
      if (sb == 8) slv_sda = ack_en && !(rdm && !aph);
      else if (rdm && !aph && !nacked) slv_sda = !txb[7-sb];
      else slv_sda = 1'b0;
    end
    pscl = scl_line; psda = sda_line;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq) break;
    end
  endtask

  // byte to send, slave acks, expected status (complete|busy|flag|nack)
  localparam logic [16:0] TXV [4] = '{
    {8'hA0, 1'b1, 8'hA2}, {8'h3C, 1'b1, 8'hA2}, {8'hC5, 1'b0, 8'hA3}, {8'h01, 1'b1, 8'hA2}};
  localparam logic [7:0] C_ = 8'h04, S_ = 8'h08, D_ = 8'h0C, B_ = 8'h14, X_ = 8'hFC;

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int s0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(S_, v); chk("R1 status after reset", v, 32'h0);
    rd(C_, v); chk("R1 control after reset", v, 32'h0);
    chk("R1 lines idle", {30'b0, scl_oe, sda_oe}, 32'h0);
    chk("R1 irq idle", {31'b0, irq}, 32'h0);

    wr(B_, 32'd4);
    wr(C_, 32'h3B0);
    repeat (40) @(negedge clk);
    rd(S_, v); chk("R2 busy after START", v, 32'h20);
    chk("R3 SCL held low after START", {31'b0, scl_oe}, 32'h1);

    for (int k = 0; k < 4; k++) begin
      ack_en = TXV[k][8];
      wr(D_, {24'b0, TXV[k][16:9]});
      wait_irq();
      chk("R4 irq on byte done", {31'b0, irq}, 32'h1);
      rd(S_, v); chk("R4 status after byte", v, {24'b0, TXV[k][7:0]});
      if (k > 0) chk("R4 byte seen MSB first", {24'b0, logb[k-1]}, {24'b0, TXV[k][16:9]});
      if (k == 1) chk("R3 SCL bit period", t_last - t_prev, 32'd32);
      wr(S_, 32'h0);
      chk("R9 irq cleared", {31'b0, irq}, 32'h0);
    end
    ack_en = 1'b1;
    repeat (100) @(negedge clk);
    chk("R3 SCL held between bytes", {31'b0, scl_oe}, 32'h1);

    s0 = starts;
    wr(C_, 32'h3B4);
    repeat (70) @(negedge clk);
    chk("R6 repeated START seen", starts, s0 + 1);
    rd(C_, v); chk("R6 restart bit not stored", v, 32'h3B0);
    wr(D_, 32'hA1);
    wait_irq();
    rd(S_, v); chk("R6 read address acked", v, 32'hA2);
    wr(S_, 32'h0);

    wr(C_, 32'h3A0);
    rd(D_, v);
    wait_irq();
    wr(S_, 32'h0);
    rd(D_, v); chk("R5 first byte after dummy read", v, 32'h5A);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq) break;
      reg_addr = S_; reg_wdata = 32'h0; reg_wr = 1'b1;
    end
    reg_wr = 1'b0;
    chk("R8 set wins over same-cycle clear", {31'b0, irq}, 32'h1);
    rd(S_, v); chk("R8 complete flag kept", v, 32'hA2);
    chk("R5 master sent ACK", {31'b0, mack}, 32'h0);
    wr(S_, 32'h0);
    wr(C_, 32'h3A8);
    rd(D_, v); chk("R5 second byte", v, 32'h5B);
    wait_irq();
    chk("R5 master sent NACK", {31'b0, mack}, 32'h1);
    wr(S_, 32'h0);
    wr(C_, 32'h3B8);
    rd(D_, v); chk("R5 last byte via transmit-mode read", v, 32'h5C);
    repeat (100) @(negedge clk);
    chk("R5 no byte started by transmit-mode read", {31'b0, scl_oe}, 32'h1);

    wr(C_, 32'h390);
    repeat (60) @(negedge clk);
    rd(S_, v); chk("R2 busy clear after STOP", v, 32'h0);
    chk("R2 lines released after STOP", {30'b0, scl_oe, sda_oe}, 32'h0);

    ack_en = 1'b0;
    wr(C_, 32'h0B0);
    repeat (40) @(negedge clk);
    wr(D_, 32'hFF);
    ext_sda = 1'b1;
    repeat (400) @(negedge clk);
    rd(S_, v); chk("R7 arbitration lost flag", v, 32'h30);
    chk("R7 lines released", {30'b0, scl_oe, sda_oe}, 32'h0);
    chk("R9 irq gated off", {31'b0, irq}, 32'h0);
    rd(C_, v); chk("R7 start bit cleared", v, 32'h090);
    ext_sda = 1'b0;
    repeat (5) @(negedge clk);
    rd(S_, v); chk("R2 busy clear on foreign STOP", v, 32'h10);
    wr(C_, 32'h390);
    chk("R9 irq from arbitration flag", {31'b0, irq}, 32'h1);
    wr(S_, 32'h0);
    chk("R8 irq low after clear", {31'b0, irq}, 32'h0);
    ack_en = 1'b1;

    wr(B_, 32'd9);
    wr(C_, 32'h3B1);
    wr(X_, 32'h1);
    wr(X_, 32'h0);
    rd(C_, v); chk("R1 control after soft reset", v, 32'h0);
    rd(B_, v); chk("R1 bit-rate after soft reset", v, 32'd63);
    wr(D_, 32'h55);
    repeat (50) @(negedge clk);
    chk("R4 data write ignored when not held", {30'b0, scl_oe, sda_oe}, 32'h0);
    rd(S_, v); chk("R4 no status from ignored write", v, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule